// File: doc/BRIEF.md
# ISDN Basic-Rate Frame Channel Demultiplexer

This block takes a serial time-division-multiplexed ISDN basic-rate stream and separates it into its three channels. Each frame carries two 64 kbps bearer channels and one 16 kbps signalling channel. The stream arrives on a data pin, together with a data clock and a frame sync pulse. The data clock is slow and asynchronous to the system clock. The block synchronises it, finds its rising edges and shifts every channel bit into its own shift register.

After four complete frames, all three shift registers hold a full word at the same moment: 32 bits for each bearer channel and 8 bits for the signalling channel. The block then copies them into holding registers and raises a ready flag. A host reads the holding registers and a status word through a small read port. If the next group of four frames completes before the host has read the data, the block raises a sticky overrun flag.

The frame engine is a five-state machine:

| State | Meaning |
|-------|---------|
| `ST_HUNT` | No frame sync seen since reset; bits are ignored. |
| `ST_B1` | Collecting the 8 bits of the first bearer channel. |
| `ST_B2` | Collecting the 8 bits of the second bearer channel. |
| `ST_DCH` | Collecting the 2 signalling bits. |
| `ST_GAP` | Frame complete; bits up to the next sync are ignored. |

Its transitions are as follows:
- **sync**: any state goes to `ST_B1` on a bit that has frame sync high. When that bit arrives in `ST_B1`, `ST_B2` or `ST_DCH`, the transition is an *abort*.
- **b1_done**: `ST_B1` goes to `ST_B2` after 8 bits.
- **b2_done**: `ST_B2` goes to `ST_DCH` after 8 bits.
- **d_done**: `ST_DCH` goes to `ST_GAP` after 2 bits. On this transition the frame-in-group count advances, or the group loads if this was the fourth frame.

Top module: `isdn_frame_demux`

## Requirements
- R1: After a bit sampled with frame sync high, frame bits 0–7 go to bearer channel B1, bits 8–15 go to B2, and bits 16–17 go to the signalling channel D. Each channel is received MSB first. Data is sampled on rising edges of the data clock.
- R2: Within a group, frame k (k = 0..3) lands in bits [31-8k:24-8k] of the B1 and B2 words and in bits [7-2k:6-2k] of the D byte. The earliest frame therefore sits in the most significant position.
- R3: All three holding registers update together when the last D bit of the fourth complete frame of a group is received, and at no earlier point.
- R4: The status word at read address 3 has bit 0 = ready and bit 1 = overrun, with all other bits zero. Ready is set when a group loads. It is cleared by reading address 0 (B1), 1 (B2) or 2 (D, zero-extended to 32 bits).
- R5: If a group loads while ready is still set, overrun is set and the newest group replaces the holding contents.
- R6: Overrun stays set until the status word is read, and that read clears it.
- R7: A frame sync that arrives before all 18 channel bits of a frame have been received discards the partial frame and resets the frame-in-group count to zero.
- R8: Bits received before the first frame sync, and bits after bit 17 of a frame, affect no register.
- R9: After reset, all holding registers read zero and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial data clock, asynchronous to `clk` |
| ser_sync | input | 1 | Frame sync, sampled on rising edges of `ser_clk` |
| ser_din | input | 1 | Serial data in, sampled on rising edges of `ser_clk` |
| rd_en | input | 1 | Read strobe; side effects occur at the clock edge |
| rd_addr | input | 2 | 0 = B1, 1 = B2, 2 = D, 3 = status |
| rd_data | output | 32 | Combinational read data for `rd_addr` |
| data_ready | output | 1 | A new group is waiting to be read |
| overrun | output | 1 | A group loaded before the previous one was read |

## Verification
A frame-state or bit-count error shifts channel boundaries, so the next group loads with rotated or mixed bytes. That error shows in B1, B2 or D as soon as the group completes, within four frames. A wrong frame-in-group count instead makes the ready flag rise one or more frames early or late. Reading the status word after three frames and again after the fourth exposes it. Abort handling is observed the same way: after a partial frame, only the next four clean frames may make up the loaded group.

// File: rtl/isdn_demux_pkg.sv
package isdn_demux_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_B1,
        ST_B2,
        ST_DCH,
        ST_GAP
    } frm_state_e;

    localparam logic [1:0] ADDR_B1   = 2'd0;
    localparam logic [1:0] ADDR_B2   = 2'd1;
    localparam logic [1:0] ADDR_D    = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

endpackage

// File: rtl/isdn_bit_sync.sv
module isdn_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_sync,
    input  logic ser_din,
    output logic bit_stb,
    output logic bit_val,
    output logic bit_fs
);

    // One extra stage on the clock pipe gives the edge detector its history.
    logic [STAGES:0]   sclk_p;
    logic [STAGES-1:0] din_p;
    logic [STAGES-1:0] fs_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= '0;
            din_p  <= '0;
            fs_p   <= '0;
        end else begin
            sclk_p <= (STAGES+1)'({sclk_p, ser_clk});
            din_p  <= STAGES'({din_p, ser_din});
            fs_p   <= STAGES'({fs_p, ser_sync});
        end
    end

    // Data and sync see the same delay as the clock, so they are sampled
    // with the values they had at the serial rising edge.
    assign bit_stb = sclk_p[STAGES-1] & ~sclk_p[STAGES];
    assign bit_val = din_p[STAGES-1];
    assign bit_fs  = fs_p[STAGES-1];

endmodule

// File: rtl/isdn_frame_fsm.sv
module isdn_frame_fsm
    import isdn_demux_pkg::*;
#(
    parameter int BCH_BITS = 8,
    parameter int DCH_BITS = 2,
    parameter int FRAMES   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic bit_fs,
    output logic sh_b1,
    output logic sh_b2,
    output logic sh_d,
    output logic grp_load
);

    localparam int CNT_W = $clog2(BCH_BITS);
    localparam int GRP_W = $clog2(FRAMES);
    localparam logic [CNT_W-1:0] LAST_B = CNT_W'(BCH_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DCH_BITS - 1);
    localparam logic [GRP_W-1:0] LAST_G = GRP_W'(FRAMES - 1);

    frm_state_e       st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [GRP_W-1:0] grp, grp_nxt;
    logic             abort;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_HUNT;
            cnt <= '0;
            grp <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
            grp <= grp_nxt;
        end
    end

    always_comb begin
        st_nxt   = st;
        cnt_nxt  = cnt;
        grp_nxt  = grp;
        sh_b1    = 1'b0;
        sh_b2    = 1'b0;
        sh_d     = 1'b0;
        grp_load = 1'b0;
        abort    = 1'b0;
        if (bit_stb) begin
            if (bit_fs) begin
                abort   = (st == ST_B1) || (st == ST_B2) || (st == ST_DCH);
                st_nxt  = ST_B1;
                cnt_nxt = CNT_W'(1);
                sh_b1   = 1'b1;
                if (abort) grp_nxt = '0;
            end else begin
                unique case (st)
                    ST_HUNT, ST_GAP: begin
                    end
                    ST_B1: begin
                        sh_b1 = 1'b1;
                        if (cnt == LAST_B) begin
                            st_nxt  = ST_B2;
                            cnt_nxt = '0;
                        end else begin
                            cnt_nxt = cnt + 1'b1;
                        end
                    end
                    ST_B2: begin
                        sh_b2 = 1'b1;
                        if (cnt == LAST_B) begin
                            st_nxt  = ST_DCH;
                            cnt_nxt = '0;
                        end else begin
                            cnt_nxt = cnt + 1'b1;
                        end
                    end
                    ST_DCH: begin
                        sh_d = 1'b1;
                        if (cnt == LAST_D) begin
                            st_nxt  = ST_GAP;
                            cnt_nxt = '0;
                            if (grp == LAST_G) begin
                                grp_load = 1'b1;
                                grp_nxt  = '0;
                            end else begin
                                grp_nxt = grp + 1'b1;
                            end
                        end else begin
                            cnt_nxt = cnt + 1'b1;
                        end
                    end
                    default: st_nxt = ST_HUNT;
                endcase
            end
        end
    end

    p_one_channel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sh_b1, sh_b2, sh_d}));

    p_load_on_last_d_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grp_load |-> (sh_d && st == ST_DCH && grp == LAST_G));

    p_abort_resets_grp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && bit_fs && (st == ST_B2 || st == ST_DCH)) |=> (grp == '0 && st == ST_B1));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HUNT || st == ST_GAP) && !bit_fs) |-> !(sh_b1 || sh_b2 || sh_d));

endmodule

// File: rtl/isdn_hold_regs.sv
module isdn_hold_regs
    import isdn_demux_pkg::*;
#(
    parameter int B_W = 32,
    parameter int D_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_val,
    input  logic           sh_b1,
    input  logic           sh_b2,
    input  logic           sh_d,
    input  logic           grp_load,
    input  logic           rd_en,
    input  logic [1:0]     rd_addr,
    output logic [B_W-1:0] rd_data,
    output logic           data_ready,
    output logic           overrun
);

    logic [B_W-1:0] b1_sh, b2_sh, b1_hold, b2_hold;
    logic [D_W-1:0] d_sh, d_hold, d_next;
    logic           rd_data_reg, rd_stat;

    assign d_next      = sh_d ? {d_sh[D_W-2:0], bit_val} : d_sh;
    assign rd_stat     = rd_en && (rd_addr == ADDR_STAT);
    assign rd_data_reg = rd_en && (rd_addr != ADDR_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b1_sh      <= '0;
            b2_sh      <= '0;
            d_sh       <= '0;
            b1_hold    <= '0;
            b2_hold    <= '0;
            d_hold     <= '0;
            data_ready <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            if (sh_b1) b1_sh <= {b1_sh[B_W-2:0], bit_val};
            if (sh_b2) b2_sh <= {b2_sh[B_W-2:0], bit_val};
            d_sh <= d_next;
            if (grp_load) begin
                b1_hold    <= b1_sh;
                b2_hold    <= b2_sh;
                d_hold     <= d_next;
                data_ready <= 1'b1;
            end else if (rd_data_reg) begin
                data_ready <= 1'b0;
            end
            if (grp_load && data_ready) overrun <= 1'b1;
            else if (rd_stat)           overrun <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_B1: rd_data = b1_hold;
            ADDR_B2: rd_data = b2_hold;
            ADDR_D:  rd_data = B_W'(d_hold);
            default: rd_data = B_W'({overrun, data_ready});
        endcase
    end

    p_ready_after_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grp_load |=> data_ready);

    p_ready_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_reg && !grp_load) |=> !data_ready);

    p_overrun_on_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_load && data_ready) |=> overrun);

    p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_stat) |=> overrun);

endmodule

// File: rtl/isdn_frame_demux.sv
module isdn_frame_demux
    import isdn_demux_pkg::*;
#(
    parameter int BCH_BITS    = 8,
    parameter int DCH_BITS    = 2,
    parameter int FRAMES      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_sync,
    input  logic        ser_din,
    input  logic        rd_en,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        data_ready,
    output logic        overrun
);

    localparam int B_W = BCH_BITS * FRAMES;
    localparam int D_W = DCH_BITS * FRAMES;

    logic bit_stb, bit_val, bit_fs;
    logic sh_b1, sh_b2, sh_d, grp_load;
    logic [B_W-1:0] rd_word;

    isdn_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_sync (ser_sync),
        .ser_din  (ser_din),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .bit_fs   (bit_fs)
    );

    isdn_frame_fsm #(
        .BCH_BITS (BCH_BITS),
        .DCH_BITS (DCH_BITS),
        .FRAMES   (FRAMES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .bit_fs   (bit_fs),
        .sh_b1    (sh_b1),
        .sh_b2    (sh_b2),
        .sh_d     (sh_d),
        .grp_load (grp_load)
    );

    isdn_hold_regs #(.B_W(B_W), .D_W(D_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_val    (bit_val),
        .sh_b1      (sh_b1),
        .sh_b2      (sh_b2),
        .sh_d       (sh_d),
        .grp_load   (grp_load),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_word),
        .data_ready (data_ready),
        .overrun    (overrun)
    );

    assign rd_data = 32'(rd_word);

endmodule

// File: tb/sim_isdn_frame_demux.sv
module sim_isdn_frame_demux;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_sync = 1'b0;
    logic        ser_din = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        data_ready, overrun;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isdn_frame_demux u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_sync   (ser_sync),
        .ser_din    (ser_din),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .data_ready (data_ready),
        .overrun    (overrun)
    );

    function automatic logic [7:0] v_b1(int g, int f);
        return 8'(g * 53 + f * 29 + 7);
    endfunction
    function automatic logic [7:0] v_b2(int g, int f);
        return 8'(g * 17 + f * 91 + 3);
    endfunction
    function automatic logic [1:0] v_d(int g, int f);
        return 2'(g + f * 3);
    endfunction
    function automatic logic [31:0] e_b1(int g);
        return {v_b1(g,0), v_b1(g,1), v_b1(g,2), v_b1(g,3)};
    endfunction
    function automatic logic [31:0] e_b2(int g);
        return {v_b2(g,0), v_b2(g,1), v_b2(g,2), v_b2(g,3)};
    endfunction
    function automatic logic [31:0] e_d(int g);
        return {24'd0, v_d(g,0), v_d(g,1), v_d(g,2), v_d(g,3)};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_bit(logic b, logic fs);
        @(negedge clk);
        ser_din  = b;
        ser_sync = fs;
        ser_clk  = 1'b0;
        repeat (HALF_BIT) @(negedge clk);
        ser_clk = 1'b1;
        repeat (HALF_BIT) @(negedge clk);
    endtask

    task automatic send_frame(logic [7:0] b1, logic [7:0] b2, logic [1:0] d, int tail);
        for (int i = 7; i >= 0; i--) send_bit(b1[i], i == 7);
        for (int i = 7; i >= 0; i--) send_bit(b2[i], 1'b0);
        send_bit(d[1], 1'b0);
        send_bit(d[0], 1'b0);
        for (int i = 0; i < tail; i++) send_bit(i[0], 1'b0);
    endtask

    task automatic send_partial(int nbits);
        send_bit(1'b1, 1'b1);
        for (int i = 1; i < nbits; i++) send_bit(1'b1, 1'b0);
    endtask

    task automatic send_group(int g);
        for (int f = 0; f < 4; f++)
            send_frame(v_b1(g,f), v_b2(g,f), v_d(g,f), ((g + f) % 5) * 3);
    endtask

    task automatic check_group(int g, string tag);
        logic [31:0] v;
        rd(2'd3, v); check({tag, " R4 ready set"}, v, 32'd1);
        rd(2'd0, v); check({tag, " R1 R2 B1 word"}, v, e_b1(g));
        rd(2'd1, v); check({tag, " R1 R2 B2 word"}, v, e_b2(g));
        rd(2'd2, v); check({tag, " R1 R2 D byte"}, v, e_d(g));
        rd(2'd3, v); check({tag, " R4 ready cleared by data read"}, v, 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset contents
        rd(2'd3, v); check("R9 status after reset", v, 32'd0);
        rd(2'd0, v); check("R9 B1 after reset", v, 32'd0);
        rd(2'd1, v); check("R9 B2 after reset", v, 32'd0);
        rd(2'd2, v); check("R9 D after reset", v, 32'd0);

        // R8: bits before the first sync are ignored
        for (int i = 0; i < 13; i++) send_bit(1'(i % 3 == 0), 1'b0);
        rd(2'd3, v); check("R8 no ready from pre-sync bits", v, 32'd0);

        // R3: three frames are not enough
        for (int f = 0; f < 3; f++)
            send_frame(v_b1(0,f), v_b2(0,f), v_d(0,f), f * 5);
        rd(2'd3, v); check("R3 no load after three frames", v, 32'd0);
        rd(2'd0, v); check("R3 B1 unchanged before group end", v, 32'd0);
        send_frame(v_b1(0,3), v_b2(0,3), v_d(0,3), 0);
        check_group(0, "g0");

        // sweep of groups with varied data and tail lengths
        for (int g = 1; g < 9; g++) begin
            send_group(g);
            check_group(g, "sweep");
        end

        // R5/R6: overrun on an unread group, newest data kept
        send_group(9);
        send_group(10);
        rd(2'd0, v); check("R5 newest B1 kept on overrun", v, e_b1(10));
        rd(2'd2, v); check("R5 newest D kept on overrun", v, e_d(10));
        rd(2'd3, v); check("R6 overrun sticky after data read", v, 32'd2);
        rd(2'd3, v); check("R6 overrun cleared by status read", v, 32'd0);
        check("R6 overrun port low", {31'd0, overrun}, 32'd0);

        // R7: partial frames abort and restart the group count
        send_frame(v_b1(11,0), v_b2(11,0), v_d(11,0), 2);
        send_partial(10);
        send_partial(17);
        for (int f = 0; f < 3; f++)
            send_frame(v_b1(12,f), v_b2(12,f), v_d(12,f), 4);
        rd(2'd3, v); check("R7 no load three frames after abort", v, 32'd0);
        send_frame(v_b1(12,3), v_b2(12,3), v_d(12,3), 4);
        check_group(12, "R7 abort");

        // R1: frame of exactly 18 bits followed immediately by sync
        for (int f = 0; f < 4; f++)
            send_frame(v_b1(13,f), v_b2(13,f), v_d(13,f), 0);
        check_group(13, "R1 back-to-back");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule